// File: doc/BRIEF.md
# Dual-Output Vectored Interrupt Controller

This block gathers up to 64 interrupt sources and presents them to a processor as two aggregated request lines. One line is a normal interrupt (IRQ) and the other a fast interrupt (FIQ). Each source has a raw status bit. Software can enable the source and route it to one of the two lines. The source's sensitivity, level or edge, is fixed when the block is built. For the four highest implemented sources, software can also choose which edge is captured.

Software reaches the block through a simple 32-bit register port that completes in one cycle. Every 64-bit quantity is split into two 32-bit words, and address bit 2 picks the upper word (sources 32 to 63). The working registers start at a base offset `NEW_BASE`. Addresses below that base form a legacy window: writes there are dropped and reads there return zero. Enables are changed through separate set and clear addresses. Latched edges are cleared through their own address.

Top module: `dual_vic`

## Requirements
- R1: A write to any address below `NEW_BASE` changes no state: the enable, routing and event-type registers and both outputs keep their values. A read of such an address returns zero.
- R2: Address bit 2 selects the upper word (sources 32..63), and a low bit 2 selects the lower word. Write data is ANDed with the implemented-source mask `VALID` for that word, so unimplemented sources never become set (default: sources 0..51 implemented).
- R3: A write to routing offset 0x18 (lower) or 0x1C (upper) replaces only the addressed word and leaves the other word unchanged. A routing bit of 1 sends the source to FIQ, and 0 sends it to IRQ.
- R4: A write to offset 0x20/0x24 sets the enable bits given by the ones in the data. A write to 0x28/0x2C clears those enable bits. Reading 0x20/0x24 returns the enables.
- R5: The event-type register (0x50 lower, 0x54 upper) changes only on an upper-word write, and only in the bits of `EVENT_WR` (default sources 48..51). All other bits keep their value. Event bit 1 captures a rising edge, and 0 captures a falling edge.
- R6: A write to edge-clear offset 0x58/0x5C clears the raw bits given by the data, but only for edge-sensitive sources. Raw bits of level-sensitive sources are unaffected.
- R7: Writes to IRQ status (0x00), FIQ status (0x08), raw (0x10), sensitivity (0x40), both-edge (0x48), edge status (0x60) and software set/clear (0x30, 0x38) change nothing. Reads of undefined or write-only offsets return zero.
- R8: IRQ status is raw AND enable AND NOT routing, and FIQ status is raw AND enable AND routing. `irq_o` and `fiq_o` are the OR of their status vectors.
- R9: For a level-sensitive source (sensitivity bit 1, read at 0x40), the raw bit equals the input sampled at the previous clock edge.
- R10: For an edge-sensitive source, the raw bit sets on the edge chosen by its event bit, or on either edge when its both-edge bit (0x48) is 1. It stays set until it is cleared through R6. Edge status (0x60) reads raw AND NOT sensitivity.
- R11: After reset, enables, routing and raw bits are zero, the event register holds `EVENT_RST` masked by `VALID`, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| src_in | input | 64 | Interrupt source inputs |
| irq_o | output | 1 | Aggregated normal interrupt |
| fiq_o | output | 1 | Aggregated fast interrupt |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. The bench samples it 2 ns after driving the address on a falling edge. Register writes, and source changes reaching the raw bits, take effect at the next rising edge. `irq_o` and `fiq_o` are formed from registers without further delay, so both are due one edge after the stimulus. Every stimulus is applied on a falling edge, and its result is read only after the following falling edge, which places each sample a full edge after the result is due.

// File: rtl/dual_vic.sv
module dual_vic #(
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  NEW_BASE  = 'h080,
  parameter logic [63:0]        VALID     = 64'h000F_FFFF_FFFF_FFFF,
  parameter logic [63:0]        SENSE_LVL = 64'h0000_0000_FFFF_FFFF,
  parameter logic [63:0]        BOTH_EDGE = 64'h0000_0002_0000_0000,
  parameter logic [63:0]        EVENT_RST = 64'hFFFF_FFFF_FFFF_FFFF,
  parameter logic [63:0]        EVENT_WR  = 64'h000F_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src_in,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam logic [ADDR_W-1:0] O_IRQ  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] O_FIQ  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] O_RAW  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] O_SEL  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] O_ENS  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] O_ENC  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] O_SENS = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] O_BOTH = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] O_EVT  = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] O_ECLR = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] O_ESTA = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] HI_BIT = ADDR_W'('h04);
  localparam logic [63:0]       EDGE   = VALID & ~SENSE_LVL;
  localparam logic [63:0]       LEVEL  = VALID & SENSE_LVL;

  logic [63:0] en_q, sel_q, evt_q, raw_q, prev_q;

  logic              in_new, hi, wr;
  logic [ADDR_W-1:0] off, n_off;
  logic [63:0]       wd64, eclr, rise, fall, hit, irq_st, fiq_st, rd64;

  assign in_new = bus_addr >= NEW_BASE;
  assign off    = bus_addr - NEW_BASE;
  assign hi     = off[2];
  assign n_off  = off & ~HI_BIT;
  assign wr     = bus_sel & bus_we & in_new;

  assign wd64 = hi ? {bus_wdata & VALID[63:32], 32'h0}
                   : {32'h0, bus_wdata & VALID[31:0]};

  assign eclr = (wr && n_off == O_ECLR) ? (wd64 & EDGE) : 64'h0;
  assign rise = src_in & ~prev_q;
  assign fall = ~src_in & prev_q;
  assign hit  = EDGE & ((BOTH_EDGE & (rise | fall)) |
                        (~BOTH_EDGE & evt_q & rise) |
                        (~BOTH_EDGE & ~evt_q & fall));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      raw_q  <= '0;
      prev_q <= '0;
      evt_q  <= EVENT_RST & VALID;
    end else begin
      prev_q <= src_in & VALID;
      raw_q  <= (src_in & LEVEL) | (((raw_q & ~eclr) | hit) & EDGE);
      if (wr && n_off == O_SEL)
        sel_q <= hi ? {wd64[63:32], sel_q[31:0]} : {sel_q[63:32], wd64[31:0]};
      if (wr && n_off == O_ENS)
        en_q <= en_q | wd64;
      else if (wr && n_off == O_ENC)
        en_q <= en_q & ~wd64;
      if (wr && hi && n_off == O_EVT)
        evt_q <= (evt_q & ~EVENT_WR) | (wd64 & EVENT_WR);
    end
  end

  assign irq_st = raw_q & en_q & ~sel_q;
  assign fiq_st = raw_q & en_q & sel_q;
  assign irq_o  = |irq_st;
  assign fiq_o  = |fiq_st;

  always_comb begin
    case (n_off)
      O_IRQ:   rd64 = irq_st;
      O_FIQ:   rd64 = fiq_st;
      O_RAW:   rd64 = raw_q;
      O_SEL:   rd64 = sel_q;
      O_ENS:   rd64 = en_q;
      O_SENS:  rd64 = LEVEL;
      O_BOTH:  rd64 = BOTH_EDGE & VALID;
      O_EVT:   rd64 = evt_q;
      O_ESTA:  rd64 = raw_q & EDGE;
      default: rd64 = 64'h0;
    endcase
  end

  assign bus_rdata = (bus_sel && !bus_we && in_new)
                   ? (hi ? rd64[63:32] : rd64[31:0]) : 32'h0;

endmodule

// File: rtl/dual_vic_chk.sv
module dual_vic_chk #(
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  NEW_BASE  = 'h080,
  parameter logic [63:0]        VALID     = 64'h000F_FFFF_FFFF_FFFF,
  parameter logic [63:0]        SENSE_LVL = 64'h0000_0000_FFFF_FFFF,
  parameter logic [63:0]        EVENT_WR  = 64'h000F_0000_0000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [63:0]       src_in,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [63:0]       en_q,
  input logic [63:0]       sel_q,
  input logic [63:0]       evt_q,
  input logic [63:0]       raw_q
);

  localparam logic [ADDR_W-1:0] A_SEL_LO = NEW_BASE + ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_ENS_LO = NEW_BASE + ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_EVT_HI = NEW_BASE + ADDR_W'('h54);

  logic legacy_wr, sel_lo_wr, ens_lo_wr, evt_hi_wr;
  assign legacy_wr = bus_sel && bus_we && (bus_addr < NEW_BASE);
  assign sel_lo_wr = bus_sel && bus_we && (bus_addr == A_SEL_LO);
  assign ens_lo_wr = bus_sel && bus_we && (bus_addr == A_ENS_LO);
  assign evt_hi_wr = bus_sel && bus_we && (bus_addr == A_EVT_HI);

  AST_LEGACY_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_wr |=> ($stable(en_q) && $stable(sel_q) && $stable(evt_q))); // R1

  AST_SEL_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lo_wr |=> (sel_q[63:32] == $past(sel_q[63:32]))); // R3

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ens_lo_wr |=> ((en_q[31:0] & $past(bus_wdata) & VALID[31:0]) ==
                   ($past(bus_wdata) & VALID[31:0]))); // R4

  AST_EVENT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_hi_wr |=> $stable(evt_q)); // R5

  AST_EVENT_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hi_wr |=> ((evt_q & ~EVENT_WR) == ($past(evt_q) & ~EVENT_WR))); // R5

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 64'h0) |-> (!irq_o && !fiq_o)); // R8

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & SENSE_LVL & VALID) ==
                      ($past(src_in) & SENSE_LVL & VALID))); // R9

endmodule

bind dual_vic dual_vic_chk #(
  .ADDR_W(ADDR_W), .NEW_BASE(NEW_BASE), .VALID(VALID),
  .SENSE_LVL(SENSE_LVL), .EVENT_WR(EVENT_WR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_in(src_in),
  .irq_o(irq_o), .fiq_o(fiq_o), .en_q(en_q), .sel_q(sel_q),
  .evt_q(evt_q), .raw_q(raw_q)
);

// File: tb/dual_vic_tb_top.sv
module dual_vic_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src = '0;
  logic        irq_o, fiq_o;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  dual_vic dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    chk(rq, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R11 irq status", 12'h080, 32'h0);
    rd_chk("R11 enable lo", 12'h0A0, 32'h0);
    rd_chk("R11 event hi", 12'h0D4, 32'h000F_FFFF);
    rd_chk("R11 event lo", 12'h0D0, 32'hFFFF_FFFF);
    chk("R11 outputs", {30'h0, irq_o, fiq_o}, 32'h0);
  endtask

  task automatic t_level;
    set_src(5, 1'b1);
    wr(12'h0A0, 32'h20);
    chk("R8 irq_o", {31'h0, irq_o}, 32'h1);
    chk("R8 fiq_o", {31'h0, fiq_o}, 32'h0);
    rd_chk("R8 irq status", 12'h080, 32'h20);
    rd_chk("R9 raw level", 12'h090, 32'h20);
    wr(12'h098, 32'h20);
    chk("R8 routed outputs", {30'h0, irq_o, fiq_o}, 32'h1);
    rd_chk("R8 fiq status", 12'h088, 32'h20);
    wr(12'h0D8, 32'h20);
    rd_chk("R6 level kept", 12'h090, 32'h20);
    set_src(5, 1'b0);
    rd_chk("R9 raw follows low", 12'h090, 32'h0);
    chk("R9 fiq drops", {31'h0, fiq_o}, 32'h0);
    wr(12'h098, 32'h0);
    wr(12'h0A8, 32'h20);
  endtask

  task automatic t_select_half;
    wr(12'h09C, 32'h1);
    wr(12'h098, 32'hFFFF_FFFF);
    rd_chk("R3 upper kept", 12'h09C, 32'h1);
    wr(12'h09C, 32'h0);
    rd_chk("R3 lower kept", 12'h098, 32'hFFFF_FFFF);
    wr(12'h098, 32'h0);
  endtask

  task automatic t_enable;
    wr(12'h0A0, 32'hF0);
    wr(12'h0A8, 32'h30);
    rd_chk("R4 set then clear", 12'h0A0, 32'hC0);
    wr(12'h0A4, 32'hFFFF_FFFF);
    rd_chk("R2 upper masked", 12'h0A4, 32'h000F_FFFF);
    wr(12'h0A8, 32'hFFFF_FFFF);
    rd_chk("R4 lower cleared", 12'h0A0, 32'h0);
    rd_chk("R2 upper untouched", 12'h0A4, 32'h000F_FFFF);
    wr(12'h0AC, 32'hFFFF_FFFF);
    rd_chk("R4 upper cleared", 12'h0A4, 32'h0);
  endtask

  task automatic t_edge;
    set_src(32, 1'b1);
    rd_chk("R10 rising latched", 12'h094, 32'h1);
    set_src(32, 1'b0);
    rd_chk("R10 held after fall", 12'h094, 32'h1);
    rd_chk("R10 edge status", 12'h0E4, 32'h1);
    wr(12'h0A4, 32'h1);
    chk("R8 edge irq", {31'h0, irq_o}, 32'h1);
    wr(12'h0DC, 32'h1);
    rd_chk("R6 edge cleared", 12'h094, 32'h0);
    chk("R6 irq gone", {31'h0, irq_o}, 32'h0);
    wr(12'h0AC, 32'h1);
    wr(12'h0D0, 32'h0);
    rd_chk("R5 lower write ignored", 12'h0D0, 32'hFFFF_FFFF);
    wr(12'h0D4, 32'h0);
    rd_chk("R5 only top four", 12'h0D4, 32'h0000_FFFF);
    set_src(48, 1'b1);
    rd_chk("R10 falling mode ignores rise", 12'h094, 32'h0);
    set_src(48, 1'b0);
    rd_chk("R10 falling latched", 12'h094, 32'h0001_0000);
    wr(12'h0DC, 32'h0001_0000);
    rd_chk("R6 clear src48", 12'h094, 32'h0);
    set_src(33, 1'b1);
    rd_chk("R10 both rise", 12'h094, 32'h2);
    wr(12'h0DC, 32'h2);
    set_src(33, 1'b0);
    rd_chk("R10 both fall", 12'h094, 32'h2);
    wr(12'h0DC, 32'h2);
    wr(12'h0D4, 32'hFFFF_FFFF);
    rd_chk("R5 restore", 12'h0D4, 32'h000F_FFFF);
  endtask

  task automatic t_legacy;
    set_src(3, 1'b1);
    wr(12'h020, 32'hFFFF_FFFF);
    chk("R1 no irq", {31'h0, irq_o}, 32'h0);
    rd_chk("R1 enable unchanged", 12'h0A0, 32'h0);
    wr(12'h054, 32'h0);
    rd_chk("R1 event unchanged", 12'h0D4, 32'h000F_FFFF);
    rd_chk("R1 legacy read zero", 12'h010, 32'h0);
  endtask

  task automatic t_readonly;
    wr(12'h0C0, 32'h0);
    rd_chk("R7 sensitivity", 12'h0C0, 32'hFFFF_FFFF);
    wr(12'h0CC, 32'h0);
    rd_chk("R7 both-edge", 12'h0CC, 32'h2);
    wr(12'h090, 32'h0);
    rd_chk("R7 raw write ignored", 12'h090, 32'h8);
    wr(12'h0B0, 32'hFFFF_FFFF);
    wr(12'h0B4, 32'hFFFF_FFFF);
    rd_chk("R7 sw set no effect", 12'h094, 32'h0);
    chk("R7 outputs quiet", {30'h0, irq_o, fiq_o}, 32'h0);
    rd_chk("R7 undefined zero", 12'h0F0, 32'h0);
    rd_chk("R7 write-only zero", 12'h0A8, 32'h0);
    wr(12'h0E4, 32'h0);
    rd_chk("R7 edge status write", 12'h0E4, 32'h0);
    set_src(3, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_select_half();
    t_enable();
    t_edge();
    t_legacy();
    t_readonly();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule